// File: doc/BRIEF.md
# Host Command Gate Output Controller

This block watches write cycles from a host processor on an 8-bit parallel slave port and drives a single gate output pin entirely in hardware. The host sends a command byte of 0xD1 followed by one data byte; bit 1 of that data byte becomes the new pin level. No firmware or interrupt takes part in the update, so the pin follows the host much faster than a software-serviced path.

The host strobe, chip select, command/data select and data bus are brought into the local clock domain through a two-stage synchroniser. The end of each write is taken from the rising edge of the synchronised write strobe. A local enable bit switches the hardware function on. When it is off, the pin shows the port data register value. A local data-direction bit decides whether the pin is driven at all.

Top module: `host_gate_ctrl`

## Requirements
- R1: After reset, the gate level is 1, so `gate_out` reads 1 once `gate_en` is 1.
- R2: `gate_oe` equals `pin_dir` at all times. The pin is driven only when `pin_dir` is 1.
- R3: While `gate_en` is 0, `gate_out` follows `port_dr`, and any pending gate command is cleared. A 0xD1 command followed by a data write made while disabled leaves the gate level unchanged. A 0xD1 command issued before disabling does not survive a disable/enable cycle.
- R4: A data write (`hst_cmd`=0) whose bit 1 is 1 sets the gate level to 1 when it follows a 0xD1 command write (`hst_cmd`=1).
- R5: A data write whose bit 1 is 0 clears the gate level to 0 when it follows a 0xD1 command write.
- R6: A command write with any value other than 0xD1 cancels a pending 0xD1. A data write after it leaves the gate level unchanged.
- R7: Only the first data write after a 0xD1 command updates the gate level. Later data writes with no new 0xD1 have no effect.
- R8: Writes made while `hst_cs_n` is 1 are ignored. They neither arm the gate command nor update the gate level, and they do not disturb a pending command.
- R9: The gate level changes on the third rising clock edge after the rising edge of `hst_wr_n`, and not on either of the two edges before it.
- R10: Only bit 1 of the data byte decides the new level. The other seven bits have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gate_en | input | 1 | Enable for the hardware gate function |
| pin_dir | input | 1 | Data-direction bit of the pin, 1 = output |
| port_dr | input | 1 | Port data register value shown while disabled |
| hst_cs_n | input | 1 | Host chip select for this channel, active low |
| hst_wr_n | input | 1 | Host write strobe, active low |
| hst_cmd | input | 1 | Host command/data select, 1 = command, 0 = data |
| hst_data | input | DW | Host data bus |
| gate_out | output | 1 | Gate pin level |
| gate_oe | output | 1 | Gate pin output enable |

## Verification
The only internal state is the pending-command flag and the gate level. A wrong pending flag stays hidden until the next data write. It then shows either as a missed update or as a spurious one on `gate_out`, three clock edges after that write's strobe rises. For this reason each cancelling or ignored stimulus is followed by a data write whose bit 1 differs from the current level, so that a wrongly armed flag shows up at once. A wrong gate level is visible on `gate_out` as soon as `gate_en` is 1. The latency case samples the pin two and three edges after the strobe rises, so that a missing or extra synchroniser stage is caught.

// File: rtl/host_gate_ctrl.sv
module host_gate_ctrl #(
  parameter int DW       = 8,
  parameter int SYNC     = 2,
  parameter int GATE_BIT = 1,
  parameter logic [DW-1:0] GATE_CMD = 8'hD1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gate_en,
  input  logic          pin_dir,
  input  logic          port_dr,
  input  logic          hst_cs_n,
  input  logic          hst_wr_n,
  input  logic          hst_cmd,
  input  logic [DW-1:0] hst_data,
  output logic          gate_out,
  output logic          gate_oe
);

  logic [SYNC-1:0] wr_sh, cs_sh, cmd_sh;
  logic [DW-1:0]   dat_sh [SYNC];
  logic            wr_d, pend, gate_q;

  wire          wr_s  = wr_sh[SYNC-1];
  wire          cs_s  = cs_sh[SYNC-1];
  wire          cmd_s = cmd_sh[SYNC-1];
  wire [DW-1:0] dat_s = dat_sh[SYNC-1];
  wire          wr_rise = wr_s & ~wr_d;
  wire          hit     = wr_rise & ~cs_s & gate_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_sh  <= '1;
      cs_sh  <= '1;
      cmd_sh <= '0;
      for (int i = 0; i < SYNC; i++) dat_sh[i] <= '0;
    end else begin
      wr_sh  <= {wr_sh[SYNC-2:0], hst_wr_n};
      cs_sh  <= {cs_sh[SYNC-2:0], hst_cs_n};
      cmd_sh <= {cmd_sh[SYNC-2:0], hst_cmd};
      dat_sh[0] <= hst_data;
      for (int i = 1; i < SYNC; i++) dat_sh[i] <= dat_sh[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_d   <= 1'b1;
      pend   <= 1'b0;
      gate_q <= 1'b1;
    end else begin
      wr_d <= wr_s;
      if (!gate_en) begin
        pend <= 1'b0;
      end else if (hit) begin
        if (cmd_s) begin
          pend <= (dat_s == GATE_CMD);
        end else if (pend) begin
          gate_q <= dat_s[GATE_BIT];
          pend   <= 1'b0;
        end
      end
    end
  end

  assign gate_oe  = pin_dir;
  assign gate_out = gate_en ? gate_q : port_dr;

  // R3: disabling clears the pending command
  assert_disable_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en |=> !pend);

  // R9: level moves only on a completed strobe
  assert_level_only_on_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_rise |=> $stable(gate_q));

  // R8: other-channel writes touch nothing
  assert_other_channel_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rise && cs_s && gate_en) |=> ($stable(gate_q) && $stable(pend)));

  // R7: a data write always consumes the pending command
  assert_data_consumes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rise && !cs_s && !cmd_s) |=> !pend);

  // R4 / R5 / R10: armed data write loads the selected bit
  assert_armed_load_R4_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !cmd_s && pend) |=> (gate_q == $past(dat_s[GATE_BIT])));

  // R7: unarmed data write leaves level alone
  assert_unarmed_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rise && !cmd_s && !pend) |=> $stable(gate_q));

endmodule

// File: tb/tb_host_gate_ctrl.sv
module tb_host_gate_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gate_en = 1'b1, pin_dir = 1'b1, port_dr = 1'b0;
  logic hst_cs_n = 1'b1, hst_wr_n = 1'b1, hst_cmd = 1'b0;
  logic [7:0] hst_data = 8'h00;
  logic gate_out, gate_oe;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  host_gate_ctrl dut (
    .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .pin_dir(pin_dir),
    .port_dr(port_dr), .hst_cs_n(hst_cs_n), .hst_wr_n(hst_wr_n),
    .hst_cmd(hst_cmd), .hst_data(hst_data), .gate_out(gate_out),
    .gate_oe(gate_oe)
  );

  // {cs_n, cmd, data[7:0], expected gate_out, requirement number}
  localparam logic [14:0] VEC [16] = '{
    {1'b0, 1'b1, 8'hD1, 1'b1, 4'd4},  // R4 arm
    {1'b0, 1'b0, 8'h00, 1'b0, 4'd5},  // R5 clear
    {1'b0, 1'b1, 8'hD1, 1'b0, 4'd4},
    {1'b0, 1'b0, 8'h02, 1'b1, 4'd4},  // R4 set, R10 single bit
    {1'b0, 1'b0, 8'h00, 1'b1, 4'd7},  // R7 second data ignored
    {1'b0, 1'b1, 8'hD1, 1'b1, 4'd6},
    {1'b0, 1'b1, 8'h55, 1'b1, 4'd6},  // R6 cancel
    {1'b0, 1'b0, 8'h00, 1'b1, 4'd6},  // R6 no update
    {1'b1, 1'b1, 8'hD1, 1'b1, 4'd8},  // R8 other channel cmd
    {1'b0, 1'b0, 8'h00, 1'b1, 4'd8},  // R8 not armed
    {1'b0, 1'b1, 8'hD1, 1'b1, 4'd8},
    {1'b1, 1'b0, 8'h00, 1'b1, 4'd8},  // R8 other channel data
    {1'b0, 1'b0, 8'hFD, 1'b0, 4'd10}, // R10 bit 1 only
    {1'b0, 1'b1, 8'hD1, 1'b0, 4'd4},
    {1'b0, 1'b1, 8'hD1, 1'b0, 4'd4},
    {1'b0, 1'b0, 8'h02, 1'b1, 4'd4}
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic host_write(input logic cs, input logic c, input logic [7:0] d);
    @(negedge clk);
    hst_cs_n = cs; hst_cmd = c; hst_data = d; hst_wr_n = 1'b0;
    repeat (3) @(negedge clk);
    hst_wr_n = 1'b1;
    repeat (5) @(negedge clk);
    hst_cs_n = 1'b1;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", gate_out, 1'b1);
    check("R2", gate_oe, 1'b1);
    pin_dir = 1'b0; #1;
    check("R2", gate_oe, 1'b0);
    pin_dir = 1'b1; #1;
    check("R2", gate_oe, 1'b1);

    for (int i = 0; i < 16; i++) begin
      host_write(VEC[i][14], VEC[i][13], VEC[i][12:5]);
      checks++;
      if (gate_out !== VEC[i][4]) begin
        errors++;
        $display("FAIL R%0d (vector %0d): actual %b expected %b",
                 VEC[i][3:0], i, gate_out, VEC[i][4]);
      end
    end

    // R3: disabled pin follows port_dr, sequence has no effect
    gate_en = 1'b0; port_dr = 1'b0; #1;
    check("R3", gate_out, 1'b0);
    port_dr = 1'b1; #1;
    check("R3", gate_out, 1'b1);
    port_dr = 1'b0;
    host_write(1'b0, 1'b1, 8'hD1);
    host_write(1'b0, 1'b0, 8'h00);
    gate_en = 1'b1; #1;
    check("R3", gate_out, 1'b1);
    host_write(1'b0, 1'b0, 8'h00);
    check("R3", gate_out, 1'b1);

    // R3: pending command lost across a disable
    host_write(1'b0, 1'b1, 8'hD1);
    @(negedge clk); gate_en = 1'b0;
    repeat (2) @(negedge clk); gate_en = 1'b1;
    host_write(1'b0, 1'b0, 8'h00);
    check("R3", gate_out, 1'b1);

    // R9: latency of three clock edges after strobe rise
    host_write(1'b0, 1'b1, 8'hD1);
    @(negedge clk);
    hst_cs_n = 1'b0; hst_cmd = 1'b0; hst_data = 8'h00; hst_wr_n = 1'b0;
    repeat (3) @(negedge clk);
    hst_wr_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R9", gate_out, 1'b1);
    @(negedge clk);
    check("R9", gate_out, 1'b0);
    repeat (3) @(negedge clk);
    hst_cs_n = 1'b1;

    // R1: reset mid-run restores level 1
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", gate_out, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule